// File: doc/BRIEF.md
# Wake-up and kickstart interrupt controller

This block holds an eight-bit extended control register and two sticky event flags for a real-time clock. It drives an active-low power-control output, the output enable for that output and an active-low interrupt line. One event source is a wake-up alarm match strobe. The other is a debounced, active-low kickstart input. The kickstart input is synchronized, and each of its falling edges sets the kickstart flag once. The wake-up strobe sets the wake flag directly.

The outputs depend on whether main supply is present. While supply is absent, an enabled pending event pulls the power-control output low so that the system can be switched on. The interrupt stays released until supply returns, and it then asserts at once. While supply is present, the same event asserts both outputs together. A keep-drive bit in the control register decides what the power-control output does during power-fail when no event is pending: it either floats or stays driven high. Software clears the flags by writing zeros to the flag register.

Top module: `wake_kick_irq_ctrl`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x00 and `flag_rd` reads 0. `pwr_o` and `irq_n` are both 1.
- R2: When `ctrl_we` is high at a clock edge, `ctrl_rd` shows `wdata` from the next cycle. Bit 6 is the exception (see R3). The bit map is: bit 7 auxiliary battery enable, bit 6 32 kHz output enable, bit 5 crystal select, bit 4 RAM-clear enable, bit 3 PWR keep-drive, bit 2 RAM-clear interrupt enable, bit 1 wake interrupt enable, bit 0 kickstart interrupt enable.
- R3: When `vmain_ok` is high at a clock edge, `ctrl_rd[6]` is 1 from the next cycle, even if a write of 0 to that bit happens in the same cycle.
- R4: When `wake_hit` is high at a clock edge, `flag_rd[0]` (the wake flag) is 1 from the next cycle. It stays 1 until it is cleared.
- R5: A falling edge on `kick_n` sets `flag_rd[1]` (the kickstart flag) exactly once. The flag reads 1 three cycles after the first edge that samples `kick_n` low, and not earlier. Holding `kick_n` low does not set the flag again after it has been cleared.
- R6: When `flag_we` is high at a clock edge, each flag whose `wdata` bit is 0 is cleared. A `wdata` bit of 1 leaves its flag unchanged. A set event in the same cycle wins over the clear.
- R7: An active source is a flag that is 1 while its enable bit is 1. With `vmain_ok` high and any source active, both `pwr_o` and `irq_n` are 0 in the same cycle that the flag is visible.
- R8: With `vmain_ok` low and any source active, `pwr_o` is 0, `pwr_oe` is 1 and `irq_n` is 1. When `vmain_ok` then rises, `irq_n` goes to 0 in that same cycle.
- R9: A flag whose enable bit is 0 has no effect: with no active source, `pwr_o` and `irq_n` are both 1.
- R10: With no active source, `pwr_oe` is 1 while `vmain_ok` is high. While `vmain_ok` is low, `pwr_oe` equals control bit 3.
- R11: Clearing the last active flag releases `pwr_o` and `irq_n` to 1 in the cycle after the clear write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| flag_we | input | 1 | Write strobe for the flag register (write zeros to clear) |
| wdata | input | 8 | Write data for both registers |
| vmain_ok | input | 1 | Main supply present |
| wake_hit | input | 1 | Wake-up alarm match strobe |
| kick_n | input | 1 | Debounced active-low kickstart input |
| ctrl_rd | output | 8 | Control register contents |
| flag_rd | output | 2 | Flags: bit 0 wake, bit 1 kickstart |
| pwr_o | output | 1 | Active-low power-control output value |
| pwr_oe | output | 1 | Output enable for pwr_o (0 means high-Z) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps every combination of the following: supply state, the two enable bits, the keep-drive bit and the two flags. For each case it compares all three outputs with values computed from R7 to R10. A design that tied the interrupt to the flag alone would assert the interrupt during power-fail. A design that floated the power-control output whenever supply was absent would hide the wake-up request.

The bench also targets the following cases:
- The kickstart path is checked for its exact latency. It is also checked for a single set while the input is held low after a clear. An edge detector built as a level detector would set the flag again.
- A set and a clear in the same cycle are checked, and so is a flag write of ones. A design with the wrong priority would lose events.
- A write of 0 to bit 6 while supply is present is checked. A design that did not force bit 6 would read back 0 there.

// File: rtl/wkic_pkg.sv
// Shared constants for the wake/kickstart interrupt controller.
// Assumes an eight-bit control register whose bit positions are fixed by the
// software-visible map given in the brief.
package wkic_pkg;
    localparam int CTRL_W    = 8;
    localparam int FLAG_W    = 2;
    localparam int B_AUXBAT  = 7;
    localparam int B_OUT32K  = 6;
    localparam int B_XTAL    = 5;
    localparam int B_RCLREN  = 4;
    localparam int B_KEEPDRV = 3;
    localparam int B_RCLRIE  = 2;
    localparam int B_WAKEIE  = 1;
    localparam int B_KICKIE  = 0;
    localparam int F_WAKE    = 0;
    localparam int F_KICK    = 1;
endpackage

// File: rtl/wkic_ctrl.sv
// Extended control register. A write stores wdata. Whenever main supply is
// present, the 32 kHz output enable bit is forced to 1.
// Assumes the supply indication is already synchronous to clk.
module wkic_ctrl
    import wkic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              vmain_ok,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [CTRL_W-1:0] force_mask;

    // Build the mask of bits that supply presence forces high.
    always_comb begin
        force_mask = '0;
        force_mask[B_OUT32K] = vmain_ok;
    end

    // Register update: write data, then OR in the forced bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we)
            ctrl_q <= wdata | force_mask;
        else
            ctrl_q <= ctrl_q | force_mask;
    end

    // R3
    force32k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vmain_ok |=> ctrl_q[B_OUT32K]);
endmodule

// File: rtl/wkic_kick_edge.sv
// Synchronizer and falling-edge detector for the kickstart input.
// Assumes the input is already debounced. Idle level is high.
// fall_o is a one-cycle pulse for each high-to-low transition.
module wkic_kick_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_n,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw input through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], kick_n};
            prev_q <= sync_q[LAST];
        end
    end

    // A falling edge is a synchronized low whose previous level was high.
    always_comb fall_o = prev_q & ~sync_q[LAST];

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/wkic_flags.sv
// Sticky event flags. A set input raises its flag. A flag write clears each
// flag whose data bit is 0. A set in the same cycle wins over the clear.
module wkic_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: set has priority over the clear-by-zero write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[i] <= 1'b0;
            else if (set_i[i])
                flag_o[i] <= 1'b1;
            else if (clr_we && !clr_data[i])
                flag_o[i] <= 1'b0;
        end

        // R4
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !clr_we) |=> flag_o[i]);

        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
    end
endmodule

// File: rtl/wkic_gate.sv
// Output gating. Combines the enabled flags with the supply state to drive
// the active-low power-control output, its enable and the interrupt.
// Purely combinational, so outputs follow flag and supply changes at once.
module wkic_gate
    import wkic_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic [FLAG_W-1:0] flag_q,
    input  logic              vmain_ok,
    output logic              pwr_o,
    output logic              pwr_oe,
    output logic              irq_n
);
    logic [FLAG_W-1:0] enable;
    logic              active;

    // Map each flag to its enable bit in the control register.
    always_comb begin
        enable         = '0;
        enable[F_WAKE] = ctrl_q[B_WAKEIE];
        enable[F_KICK] = ctrl_q[B_KICKIE];
    end

    // Any enabled pending source requests power and, with supply, interrupts.
    always_comb begin
        active = |(flag_q & enable);
        pwr_o  = ~active;
        pwr_oe = vmain_ok | ctrl_q[B_KEEPDRV] | active;
        irq_n  = ~(active & vmain_ok);
    end
endmodule

// File: rtl/wake_kick_irq_ctrl.sv
// Top level of the wake-up and kickstart interrupt controller.
// Assumes all inputs except kick_n are synchronous to clk.
// kick_n is synchronized internally.
module wake_kick_irq_ctrl
    import wkic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              flag_we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              vmain_ok,
    input  logic              wake_hit,
    input  logic              kick_n,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [FLAG_W-1:0] flag_rd,
    output logic              pwr_o,
    output logic              pwr_oe,
    output logic              irq_n
);
    logic              kick_fall;
    logic [FLAG_W-1:0] set_vec;

    wkic_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (wdata),
        .vmain_ok (vmain_ok),
        .ctrl_q   (ctrl_rd)
    );

    wkic_kick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_n (kick_n),
        .fall_o (kick_fall)
    );

    // Route the event strobes to their flag positions.
    always_comb begin
        set_vec         = '0;
        set_vec[F_WAKE] = wake_hit;
        set_vec[F_KICK] = kick_fall;
    end

    wkic_flags #(.N(FLAG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_we   (flag_we),
        .clr_data (wdata[FLAG_W-1:0]),
        .flag_o   (flag_rd)
    );

    wkic_gate u_gate (
        .ctrl_q   (ctrl_rd),
        .flag_q   (flag_rd),
        .vmain_ok (vmain_ok),
        .pwr_o    (pwr_o),
        .pwr_oe   (pwr_oe),
        .irq_n    (irq_n)
    );

    // R8
    irq_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vmain_ok |-> irq_n);

    // R10
    oe_with_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vmain_ok |-> pwr_oe);

    // R7
    irq_implies_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> !pwr_o);
endmodule

// File: tb/sim_wake_kick_irq_ctrl.sv
// Self-checking bench: directed checks on registers and flags, then a sweep
// over supply, enables, keep-drive and flag state.
module sim_wake_kick_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic       flag_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       vmain_ok = 1'b0;
    logic       wake_hit = 1'b0;
    logic       kick_n = 1'b1;
    logic [7:0] ctrl_rd;
    logic [1:0] flag_rd;
    logic       pwr_o, pwr_oe, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wake_kick_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .flag_we(flag_we),
        .wdata(wdata), .vmain_ok(vmain_ok), .wake_hit(wake_hit),
        .kick_n(kick_n), .ctrl_rd(ctrl_rd), .flag_rd(flag_rd),
        .pwr_o(pwr_o), .pwr_oe(pwr_oe), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk); ctrl_we = 1'b1; wdata = d;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_flag(input logic [7:0] d);
        @(negedge clk); flag_we = 1'b1; wdata = d;
        @(negedge clk); flag_we = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_hit = 1'b1;
        @(negedge clk); wake_hit = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick_n = 1'b0;
        tick(3);
        kick_n = 1'b1;
        tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctrl", ctrl_rd, 8'h00);
        chk("R1 flags", flag_rd, 0);
        chk("R1 pwr_o", pwr_o, 1);
        chk("R1 irq_n", irq_n, 1);

        // R2 plain writes without supply
        wr_ctrl(8'hA5); #1;
        chk("R2 write A5", ctrl_rd, 8'hA5);
        wr_ctrl(8'h1A); #1;
        chk("R2 write 1A", ctrl_rd, 8'h1A);

        // R3 forced 32 kHz bit with supply present
        @(negedge clk); vmain_ok = 1'b1;
        tick(1); #1;
        chk("R3 forced", ctrl_rd, 8'h5A);
        wr_ctrl(8'h00); #1;
        chk("R3 write zero", ctrl_rd, 8'h40);
        @(negedge clk); vmain_ok = 1'b0;
        wr_ctrl(8'h00); #1;
        chk("R2 write zero no supply", ctrl_rd, 8'h00);

        // R4 wake flag set and sticky
        pulse_wake(); #1;
        chk("R4 wake set", flag_rd, 1);
        tick(5); #1;
        chk("R4 wake sticky", flag_rd, 1);

        // R6 writing ones leaves flags, zero clears
        wr_flag(8'h03); #1;
        chk("R6 ones keep", flag_rd, 1);
        wr_flag(8'h02); #1;
        chk("R6 zero clears", flag_rd, 0);
        wr_flag(8'h03); #1;
        chk("R6 ones do not set", flag_rd, 0);
        // R6 set wins over same-cycle clear
        @(negedge clk); wake_hit = 1'b1; flag_we = 1'b1; wdata = 8'h00;
        @(negedge clk); wake_hit = 1'b0; flag_we = 1'b0; #1;
        chk("R6 set wins", flag_rd, 1);
        wr_flag(8'h00); #1;
        chk("R6 cleared", flag_rd, 0);

        // R5 kick latency and single set while held low
        @(negedge clk); kick_n = 1'b0;
        tick(2); #1;
        chk("R5 not yet", flag_rd, 0);
        tick(1); #1;
        chk("R5 set at 3", flag_rd, 2);
        wr_flag(8'h00); #1;
        chk("R5 cleared", flag_rd, 0);
        tick(6); #1;
        chk("R5 held low no reset", flag_rd, 0);
        @(negedge clk); kick_n = 1'b1;
        tick(4);
        pulse_kick(); #1;
        chk("R5 second pulse", flag_rd, 2);
        wr_flag(8'h00);

        // R8 supply return raises the interrupt at once; R11 release
        wr_ctrl(8'h02);
        pulse_wake(); #1;
        chk("R8 pwr low", pwr_o, 0);
        chk("R8 oe", pwr_oe, 1);
        chk("R8 irq held", irq_n, 1);
        @(negedge clk); vmain_ok = 1'b1; #1;
        chk("R8 irq on return", irq_n, 0);
        @(negedge clk); flag_we = 1'b1; wdata = 8'h00; #1;
        chk("R11 before clear", irq_n, 0);
        @(negedge clk); flag_we = 1'b0; #1;
        chk("R11 irq released", irq_n, 1);
        chk("R11 pwr released", pwr_o, 1);

        // R7 R9 R10 sweep over supply, enables, keep-drive and flags
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 4; e++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int f = 0; f < 4; f++) begin
                        int act, ex_pwr, ex_oe, ex_irq;
                        @(negedge clk); vmain_ok = s[0];
                        wr_ctrl({4'b0, p[0], 1'b0, e[1], e[0]});
                        wr_flag(8'h00);
                        if (f[0]) pulse_wake();
                        if (f[1]) pulse_kick();
                        #1;
                        act    = (f[0] & e[1]) | (f[1] & e[0]);
                        ex_pwr = act ? 0 : 1;
                        ex_oe  = (s | p | act) != 0 ? 1 : 0;
                        ex_irq = (act & s) != 0 ? 0 : 1;
                        chk("R4 R5 sweep flags", flag_rd, f);
                        chk(act != 0 ? (s != 0 ? "R7 pwr_o" : "R8 pwr_o") : "R9 pwr_o", pwr_o, ex_pwr);
                        chk("R10 pwr_oe", pwr_oe, ex_oe);
                        chk(act != 0 ? "R7 irq_n" : "R9 irq_n", irq_n, ex_irq);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule